// File: doc/BRIEF.md
# Two-Wire EEPROM Slave

This block is the serial front end of a small nonvolatile identification memory. It listens on a synchronised two-wire clock and data pair and recognises start and stop conditions. It answers to the device code `1010` and serves a 128-byte array held in registers. Hosts can write one byte or a page of up to eight bytes. They can read from the current pointer, set the pointer with a dummy write and then read, or keep reading across the whole array.

Data received in a write sequence is held in a page buffer. It reaches the array only when the stop condition arrives and only if the write-enable level is high at that moment. Committing the data starts a programming timer. While the timer runs, the slave refuses its own address.

Two single-cycle status pulses feed a surrounding mode controller. One reports that the device address was acknowledged. The other reports that a stop arrived while the device address was still being shifted in.

Top module: `eep_2w_slave`

## Requirements
- R1: After reset the slave does not pull the data line, both status pulses are low, every array byte reads FFh and the address pointer is 00h.
- R2: A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. Until a start has been seen, clocked bits get no response.
- R3: The first byte after a start is the device byte. Bits 7..4 must equal 1010, bits 3..1 are ignored, and bit 0 selects read (1) or write (0). On a match the slave acknowledges and pulses `ack_pulse_o`. On a mismatch it stays silent until the next start.
- R4: Incoming bits are taken on clock rising edges. The slave changes its data drive only after a clock falling edge. An acknowledge is driven low from the fall after bit 8 until the fall after bit 9.
- R5: In a write, the byte after the device byte is the word address, and its bit 7 is ignored. The slave acknowledges that byte and every data byte that follows.
- R6: Within a write, after each data byte only address bits 2..0 advance and bits 6..3 hold. A ninth or later byte wraps inside the 8-byte page and overwrites earlier data.
- R7: Buffered data is written to the array only at a stop, which also starts a busy time of `PROG_CYCLES` clocks. A repeated start discards the buffered data.
- R8: Buffered data is committed only if `wr_en_i` is high when the stop arrives, and then no busy time starts if it is low. Lowering `wr_en_i` during the busy time does not undo the write. With `wr_en_i` low, a word address is still accepted for a random read.
- R9: While the busy time runs, the slave does not acknowledge its device byte.
- R10: In a read, the pointer advances by one over all 7 bits after every byte sent, wrapping from 7Fh to 00h. A master acknowledge makes the slave send the next byte.
- R11: After the master withholds its acknowledge on a read byte, the slave releases the data line and stays silent until a start or stop.
- R12: After reading address n, a current-address read returns address n+1. After a write sequence whose last data byte went to address n, a current-address read returns address n.
- R13: A stop that arrives while the device byte is being received pulses `addr_stop_o` for one cycle. A stop at any later point does not pulse it.
- R14: A repeated start at any point clears the bit count and returns the slave to device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level (wired-AND of all drivers) |
| wr_en_i | input | 1 | Write-enable level; high allows array programming |
| sda_low_o | output | 1 | When high, the slave pulls the data line low |
| ack_pulse_o | output | 1 | One-cycle pulse when the device byte is acknowledged |
| addr_stop_o | output | 1 | One-cycle pulse on a stop during device-byte reception |

## Verification
Most internal faults show up at the next acknowledge slot or the next byte read back. A bit counter out of step moves the acknowledge by a clock period and corrupts the data shifted out within one byte time. A pointer that advances wrongly shows as a wrong byte in the following current-address read. Faults in the page offset or commit logic only appear after the programming time, when a sequential read returns the page contents. A busy timer that ends early or late shows as an acknowledge, or a missing one, on a device byte sent right after the stop.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,      // waiting for a start
    ST_RX,        // shifting a byte in
    ST_ACK_WAIT,  // byte taken, waiting for the fall to drive ack
    ST_ACK_HOLD,  // driving ack, waiting for the fall that ends it
    ST_TX,        // shifting a byte out
    ST_TX_REL,    // byte out, release at next fall
    ST_MACK,      // master acknowledge slot
    ST_MACK_END,  // master acked, next byte starts at next fall
    ST_WAIT_STOP  // silent until start or stop
  } eep_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } rx_kind_e;

  function automatic logic dev_match(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 4] == DEV_CODE;
  endfunction

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  // data edges only count as conditions while the clock stays high
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = ($clog2(CYCLES + 1) < 1) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  AST_TIMER_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R9

  AST_TIMER_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);  // R7

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              buf_we,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              buf_clr,
  input  logic              commit,
  output logic              has_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [SLOTS];
  logic [SLOTS-1:0]  pvalid;
  logic [BASE_W-1:0] base;

  // page buffer: one slot per in-page offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      base   <= '0;
      for (int s = 0; s < SLOTS; s++) pbuf[s] <= 8'h00;
    end else if (commit || buf_clr) begin
      pvalid <= '0;
    end else if (buf_we) begin
      base <= buf_addr[ADDR_W-1:PAGE_W];
      for (int s = 0; s < SLOTS; s++) begin
        if (buf_addr[PAGE_W-1:0] == PAGE_W'(s)) begin
          pbuf[s]   <= buf_data;
          pvalid[s] <= 1'b1;
        end
      end
    end
  end

  // array: erased to FFh, all valid slots land together at commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (pvalid[s]) mem[{base, PAGE_W'(s)}] <= pbuf[s];
      end
    end
  end

  assign rd_data  = mem[rd_addr];
  assign has_data = |pvalid;

  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !has_data);  // R7

endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave import eep_pkg::*; #(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  output logic sda_low_o,
  output logic ack_pulse_o,
  output logic addr_stop_o
);

  // in-page step for writes: low PAGE_W bits wrap, upper bits hold
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] off;
    off = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], off};
  endfunction

  // full-width step for reads
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // named internal events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, has_data, commit, data_we, rx_done, dev_hit, last_bit;
  logic [7:0] rd_data, byte_in;

  eep_state_e        state;
  rx_kind_e          kind;
  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        shr;
  logic              rw_q, wr_seen;
  logic [ADDR_W-1:0] addr_q, last_wr;

  eep_line_mon u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit),
    .busy  (busy)
  );

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (addr_q),
    .rd_data  (rd_data),
    .buf_we   (data_we),
    .buf_addr (addr_q),
    .buf_data (byte_in),
    .buf_clr  (start_ev | stop_ev),
    .commit   (commit),
    .has_data (has_data)
  );

  assign byte_in  = {shr[6:0], sda_i};
  assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));
  assign rx_done  = (state == ST_RX) && scl_rise && last_bit;
  assign dev_hit  = rx_done && (kind == RX_DEV) && dev_match(byte_in) && !busy;
  assign data_we  = rx_done && (kind == RX_WDATA);
  assign commit   = stop_ev && wr_seen && wr_en_i;

  assign ack_pulse_o = dev_hit;
  assign addr_stop_o = stop_ev && (state == ST_RX) && (kind == RX_DEV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= RX_DEV;
      bit_cnt   <= '0;
      shr       <= '0;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      last_wr   <= '0;
      wr_seen   <= 1'b0;
      sda_low_o <= 1'b0;
    end else if (start_ev) begin
      state     <= ST_RX;
      kind      <= RX_DEV;
      bit_cnt   <= '0;
      sda_low_o <= 1'b0;
      wr_seen   <= 1'b0;
      if (wr_seen) addr_q <= last_wr;
    end else if (stop_ev) begin
      state     <= ST_IDLE;
      sda_low_o <= 1'b0;
      wr_seen   <= 1'b0;
      if (wr_seen) addr_q <= last_wr;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shr     <= byte_in;
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            case (kind)
              RX_DEV: begin
                rw_q  <= byte_in[0];
                state <= dev_hit ? ST_ACK_WAIT : ST_IDLE;
              end
              RX_WADDR: begin
                addr_q <= byte_in[ADDR_W-1:0];
                state  <= ST_ACK_WAIT;
              end
              default: begin
                last_wr <= addr_q;
                addr_q  <= page_step(addr_q);
                wr_seen <= 1'b1;
                state   <= ST_ACK_WAIT;
              end
            endcase
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_low_o <= 1'b1;
          state     <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          bit_cnt <= '0;
          if (kind == RX_DEV && rw_q) begin
            shr       <= rd_data;
            sda_low_o <= ~rd_data[7];
            state     <= ST_TX;
          end else begin
            sda_low_o <= 1'b0;
            kind      <= (kind == RX_DEV) ? RX_WADDR : RX_WDATA;
            state     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) state <= ST_TX_REL;
          end else if (scl_fall) begin
            sda_low_o <= ~shr[3'd7 - bit_cnt];
          end
        end
        ST_TX_REL: if (scl_fall) begin
          sda_low_o <= 1'b0;
          state     <= ST_MACK;
        end
        ST_MACK: if (scl_rise) begin
          addr_q <= seq_step(addr_q);
          state  <= sda_i ? ST_WAIT_STOP : ST_MACK_END;
        end
        ST_MACK_END: if (scl_fall) begin
          shr       <= rd_data;
          sda_low_o <= ~rd_data[7];
          bit_cnt   <= '0;
          state     <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |-> !busy);  // R9

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_ev && !stop_ev) |=> $stable(sda_low_o));  // R4

  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_low_o && state == ST_RX && bit_cnt == '0));  // R14

  AST_QUIET_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT_STOP) |-> !sda_low_o);  // R11

  AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_pulse_o, addr_stop_o}));  // R13

  AST_COMMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!busy && has_data));  // R7

endmodule

// File: tb/sim_eep_2w_slave.sv
module sim_eep_2w_slave;
  localparam int PROG = 400;
  localparam int Q    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wren = 1'b1;
  logic sda_low, ack_p, astop, sda_line;

  int n_tests = 0, n_fail = 0, n_ack = 0, n_astop = 0, glitch = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [128];
  logic [6:0] ptr;
  logic [7:0] dat [16];

  assign sda_line = sda_m & ~sda_low;

  always #2 clk = ~clk;

  eep_2w_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .wr_en_i     (wren),
    .sda_low_o   (sda_low),
    .ack_pulse_o (ack_p),
    .addr_stop_o (astop)
  );

  always @(negedge clk) begin
    if (ack_p) n_ack++;
    if (astop) n_astop++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic tk_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(1); b = sda_line;
    wq(Q - 1); if (sda_line !== b) glitch++;
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nack);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  // own model of the write rules: offset wraps in 8-byte page
  task automatic mdl_write(input logic [6:0] a, input int n);
    logic [6:0] p;
    p = a;
    for (int i = 0; i < n; i++) begin
      p = {a[6:3], 3'(a[2:0] + i)};
      if (wren) exp_mem[p] = dat[i];
    end
    ptr = p;
  endtask

  task automatic write_seq(input logic [7:0] waddr, input int n, input string req);
    logic nk; int bad;
    bad = 0;
    tk_start();
    send_byte(8'hA0, nk); bad += nk;
    send_byte(waddr, nk); bad += nk;
    for (int i = 0; i < n; i++) begin send_byte(dat[i], nk); bad += nk; end
    tk_stop();
    chk(bad == 0, {req, " every write byte acknowledged"}, bad, 0);
    mdl_write(waddr[6:0], n);
  endtask

  task automatic read_seq(input bit rnd, input logic [6:0] a, input int n, input string req);
    logic nk; logic [7:0] v;
    tk_start();
    if (rnd) begin
      send_byte(8'hA0, nk); chk(nk == 0, {req, " dummy write ack"}, nk, 0);
      send_byte({1'b0, a}, nk); chk(nk == 0, {req, " word address ack"}, nk, 0);
      tk_start();
      ptr = a;
    end
    send_byte(8'hA1, nk); chk(nk == 0, {req, " read device ack"}, nk, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      chk(v == exp_mem[ptr], {req, " read data"}, v, exp_mem[ptr]);
      ptr = ptr + 7'd1;
    end
    tk_stop();
  endtask

  task automatic t_reset();
    chk(sda_low == 1'b0, "R1 data line released", sda_low, 0);
    chk(ack_p == 1'b0 && astop == 1'b0, "R1 pulses low", {ack_p, astop}, 0);
  endtask

  task automatic t_ignore();
    logic nk;
    scl = 1'b0; wq(Q);
    send_byte(8'hA0, nk);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    chk(nk == 1'b1, "R2 no ack without start", nk, 1);
    chk(n_ack == 0, "R2 no ack pulse without start", n_ack, 0);
  endtask

  task automatic t_cur_reset();
    read_seq(1'b0, 7'h00, 1, "R1 R12 current read after reset");
  endtask

  task automatic t_byte_write();
    int a0;
    a0 = n_astop;
    dat[0] = 8'h3C;
    write_seq(8'h95, 1, "R5");                 // bit 7 of word address ignored
    chk(n_astop == a0, "R13 no pulse on late stop", n_astop, a0);
    wq(PROG + 20);
    read_seq(1'b1, 7'h15, 1, "R5 R7 byte write readback");
  endtask

  task automatic t_page();
    logic nk; int k0;
    for (int i = 0; i < 10; i++) dat[i] = 8'h60 + 8'(i);
    write_seq(8'h1E, 10, "R6");
    k0 = n_ack;
    tk_start(); send_byte(8'hA1, nk); tk_stop();
    chk(nk == 1'b1, "R9 no ack while busy", nk, 1);
    chk(n_ack == k0, "R9 no ack pulse while busy", n_ack, k0);
    wq(PROG + 20);
    read_seq(1'b0, 7'h00, 1, "R12 current read after write");
    read_seq(1'b1, 7'h18, 8, "R6 R10 page contents");
  endtask

  task automatic t_wren();
    logic nk; logic [7:0] v;
    wren = 1'b0;
    dat[0] = 8'hA5;
    write_seq(8'h40, 1, "R8");
    tk_start(); send_byte(8'hA1, nk);
    chk(nk == 1'b0, "R8 no busy time when disabled", nk, 0);
    recv_byte(1'b1, v); tk_stop();
    chk(v == exp_mem[7'h40], "R8 R12 disabled write not stored", v, exp_mem[7'h40]);
    read_seq(1'b1, 7'h15, 1, "R8 random read with enable low");
    wren = 1'b1;
  endtask

  task automatic t_wrap();
    dat[0] = 8'h77;
    write_seq(8'h7F, 1, "R10");
    wren = 1'b0; wq(PROG + 20); wren = 1'b1;      // drop during busy time
    dat[0] = 8'h11; dat[1] = 8'h22;
    write_seq(8'h00, 2, "R10");
    wq(PROG + 20);
    read_seq(1'b1, 7'h7E, 3, "R8 R10 wrap 7Fh to 00h");
    read_seq(1'b0, 7'h00, 1, "R12 current read after read");
  endtask

  task automatic t_nack();
    logic nk, b; logic [7:0] v; int lows;
    lows = 0;
    tk_start(); send_byte(8'hA0, nk); send_byte(8'h15, nk); tk_start();
    send_byte(8'hA1, nk);
    recv_byte(1'b1, v);
    chk(v == exp_mem[7'h15], "R11 data before nack", v, exp_mem[7'h15]);
    for (int i = 0; i < 9; i++) begin get_bit(b); if (b == 1'b0) lows++; end
    tk_stop();
    chk(lows == 0, "R11 silent after nack", lows, 0);
    ptr = 7'h16;
  endtask

  task automatic t_devcode();
    logic nk1, nk2, nk; logic [7:0] v; int k0;
    k0 = n_ack;
    tk_start(); send_byte(8'hB0, nk1); send_byte(8'h00, nk2); tk_stop();
    chk(nk1 == 1'b1 && nk2 == 1'b1, "R3 wrong code ignored", {nk1, nk2}, 2'b11);
    chk(n_ack == k0, "R3 no pulse on wrong code", n_ack, k0);
    tk_start(); send_byte(8'hAE, nk);
    chk(nk == 1'b0 && n_ack == k0 + 1, "R3 ignored bits, ack pulse", n_ack, k0 + 1);
    send_byte(8'h15, nk); tk_start(); send_byte(8'hAF, nk);
    chk(nk == 1'b0, "R3 read with ignored bits set", nk, 0);
    recv_byte(1'b1, v); tk_stop();
    chk(v == 8'h3C, "R3 data read", v, 8'h3C);
    ptr = 7'h16;
  endtask

  task automatic t_astop();
    int a0;
    a0 = n_astop;
    tk_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); tk_stop();
    chk(n_astop == a0 + 1, "R13 stop inside device byte", n_astop, a0 + 1);
  endtask

  task automatic t_restart();
    logic nk; logic [7:0] v;
    tk_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    tk_start();
    send_byte(8'hA0, nk);
    chk(nk == 1'b0, "R14 restart resets bit count", nk, 0);
    send_byte(8'h50, nk); send_byte(8'h99, nk);
    tk_start(); send_byte(8'hA1, nk);
    chk(nk == 1'b0, "R7 restart starts no busy time", nk, 0);
    recv_byte(1'b1, v); tk_stop();
    chk(v == exp_mem[7'h50], "R7 restart discards data", v, exp_mem[7'h50]);
    chk(glitch == 0, "R4 output stable while clock high", glitch, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
    ptr = 7'h00;
    wq(5); rst_n = 1'b1; wq(2);
    t_reset();
    t_ignore();
    t_cur_reset();
    t_byte_write();
    t_page();
    t_wren();
    t_wrap();
    t_nack();
    t_devcode();
    t_astop();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule